// File: doc/BRIEF.md
# Banked Infrared Receive FIFO and Interval Timer

This block sits behind a small byte-wide host bus in an infrared receiver. Incoming bytes arrive on a strobed input and are queued in a 16-entry FIFO. The host drains the queue and reads its status through a banked register window. A level flag goes high once the queue holds at least a programmable number of bytes. A second bank holds the reload value of a 16-bit down-counter. When the counter runs out it raises a one-cycle expiry pulse and then reloads itself.

The host bus has four byte offsets. The upper two bits of a control register choose which bank the first three offsets reach. The control register itself is at offset 3 and answers there whatever bank is selected, so software can always switch banks. The same register also holds:

- the threshold code;
- a FIFO clear bit that clears itself;
- the timer enable;
- the tick-rate select;
- a test bit that makes the timer registers show the programmed reload value instead of the running count.

Top module: `ir_rx_bank_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the FIFO status reads 0x04 (empty only), the level flag is 0, the expiry pulse is 0 and the FIFO holds no data.
- R2: Offset 3 reads and writes the full 8-bit control register whatever bank is selected, including banks 2 and 3. Bits 7:6 select the bank seen at offsets 0 to 2.
- R3: In bank 0, offset 0 returns the oldest queued byte, and a read strobe there removes it. Bytes leave in arrival order. Offset 1 returns the status {4'b0, full, empty, overrun, level}, with the level flag at bit 0, overrun at bit 1, empty at bit 2 and full at bit 3.
- R4: The level flag is high exactly when the FIFO occupancy is at least the level chosen by control bits 5:4. The codes are 00 for 1, 01 for 4, 10 for 8 and 11 for 14 bytes.
- R5: A byte that arrives while the FIFO holds 16 entries is dropped and sets a sticky overrun bit. A read of offset 0 while the FIFO is empty returns 0 and changes nothing.
- R6: Writing control bit 1 as 1 makes it read back 1 for one cycle. At the next clock edge the bit returns to 0, the FIFO empties and overrun clears. A byte arriving in that cycle is discarded.
- R7: Setting control bit 2 loads the counter from the reload pair at the first edge after the write. After that, each tick decrements the counter. A tick that finds the counter at 0 reloads it and pulses the expiry output for one cycle, so pulses are (reload+1) ticks apart. While bit 2 is 0 the count holds.
- R8: Control bit 0 selects the tick rate. A value of 0 gives one tick per clock and 1 gives one tick every 8 clocks.
- R9: In bank 1, a write to offset 0 sets the reload low byte and a write to offset 1 sets the high byte. Reads of these offsets return the live count when control bit 3 is 0 and the reload bytes when it is 1.
- R10: In banks 2 and 3, and at offset 2 of banks 0 and 1, reads return 0 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe; removes a FIFO byte at bank 0 offset 0 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current offset and bank (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| thr_flag | output | 1 | FIFO level at or above the threshold |
| tmr_expire | output | 1 | One-cycle timer expiry pulse |

## Verification
The FIFO is filled to just under and exactly at each chosen level, so an off-by-one in the level compare or in the code-to-level mapping shows up. It is also filled past 16 entries and drained past empty, which separates a dropped byte from an overwritten one and a harmless empty read from a pointer slip. The timer runs at both tick rates with a known reload, and the measured spacing of the expiry pulses separates a (reload+1) period from a reload period and a divide-by-8 tick from a divide-by-1 tick. Bank switching writes into a reserved bank and reads back through bank 1 in test mode, which shows whether those writes were really ignored.

// File: rtl/irb_pkg.sv
`timescale 1ns/1ps
package irb_pkg;
   localparam int unsigned HOST_AW  = 2;
   localparam int unsigned HOST_DW  = 8;
   localparam logic [HOST_AW-1:0] CTRL_OFS = 2'd3;
   localparam logic [HOST_AW-1:0] OFS_LO   = 2'd0;
   localparam logic [HOST_AW-1:0] OFS_HI   = 2'd1;

   typedef enum logic [1:0] {
      BANK_FIFO  = 2'd0,
      BANK_TIMER = 2'd1,
      BANK_RSV2  = 2'd2,
      BANK_RSV3  = 2'd3
   } bank_e;

   // control register field positions
   localparam int unsigned CB_SLOW  = 0;
   localparam int unsigned CB_FLUSH = 1;
   localparam int unsigned CB_TEN   = 2;
   localparam int unsigned CB_TEST  = 3;
endpackage

// File: rtl/irb_fifo.sv
`timescale 1ns/1ps
module irb_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          overrun
);
   if (DEPTH < 14) begin : g_depth_bad
      $error("irb_fifo: DEPTH must hold the largest threshold (14)");
   end
   if (DW < 1) begin : g_dw_bad
      $error("irb_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else if (flush) begin
         wp      <= '0;
         rp      <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         count   <= count + CW'(do_push) - CW'(do_pop);
         overrun <= overrun | (push && full);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   assign dout = empty ? '0 : mem[rp];

   // R5
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   // R5
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !flush) |=> overrun);
   // R6
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !overrun));
   // R5
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (dout == '0));
endmodule

// File: rtl/irb_tick.sv
`timescale 1ns/1ps
module irb_tick #(
   parameter int unsigned DIV = 8,
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);
   if (DIV < 2) begin : g_div_bad
      $error("irb_tick: DIV must be at least 2");
   end

   logic [PW-1:0] pc;
   logic          wrap;

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      assign wrap = &pc;
      always_ff @(posedge clk) begin
         if (!rst_n || !run) pc <= '0;
         else                pc <= pc + 1'b1;
      end
   end else begin : g_mod
      assign wrap = (pc == PW'(DIV - 1));
      always_ff @(posedge clk) begin
         if (!rst_n || !run) pc <= '0;
         else if (wrap)      pc <= '0;
         else                pc <= pc + 1'b1;
      end
   end

   assign tick = run && (slow ? wrap : 1'b1);
endmodule

// File: rtl/irb_timer.sv
`timescale 1ns/1ps
module irb_timer #(
   parameter int unsigned TW  = 16,
   parameter int unsigned DIV = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          slow,
   input  logic [TW-1:0] reload,
   output logic [TW-1:0] count,
   output logic          expire
);
   if (TW < 9 || TW > 16) begin : g_tw_bad
      $error("irb_timer: TW must fit the low/high byte pair");
   end

   logic en_d, tick;

   irb_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en && en_d),
      .slow (slow),
      .tick (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_d   <= 1'b0;
         count  <= '0;
         expire <= 1'b0;
      end else if (!en) begin
         en_d   <= 1'b0;
         expire <= 1'b0;
      end else if (!en_d) begin
         en_d   <= 1'b1;
         count  <= reload;
         expire <= 1'b0;
      end else if (tick) begin
         if (count == '0) begin
            count  <= reload;
            expire <= 1'b1;
         end else begin
            count  <= count - 1'b1;
            expire <= 1'b0;
         end
      end else begin
         expire <= 1'b0;
      end
   end

   // R7
   exp_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(en));
   // R7
   load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_d) |=> (count == $past(reload)));
   // R7
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count));
endmodule

// File: rtl/ir_rx_bank_ctrl.sv
`timescale 1ns/1ps
module ir_rx_bank_ctrl
   import irb_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned TMR_W      = 16,
   parameter int unsigned TICK_DIV   = 8,
   localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic               host_wr,
   input  logic               host_rd,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata,
   input  logic               rx_valid,
   input  logic [HOST_DW-1:0] rx_data,
   output logic               thr_flag,
   output logic               tmr_expire
);
   logic [HOST_DW-1:0] ctrl_q;
   logic [TMR_W-1:0]   rl_q, cnt;
   logic [15:0]        rl16, cnt16;
   bank_e              bank;
   logic               flush, is_ctrl;
   logic [HOST_DW-1:0] f_dout, status;
   logic [CW-1:0]      f_cnt, lvl;
   logic               f_full, f_empty, f_ovr;

   assign bank    = bank_e'(ctrl_q[7:6]);
   assign flush   = ctrl_q[CB_FLUSH];
   assign is_ctrl = (host_addr == CTRL_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n)                  ctrl_q <= '0;
      else if (host_wr && is_ctrl) ctrl_q <= host_wdata;
      else                         ctrl_q[CB_FLUSH] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rl_q <= '0;
      end else if (host_wr && !is_ctrl && bank == BANK_TIMER) begin
         if (host_addr == OFS_LO) rl_q[7:0] <= host_wdata;
         if (host_addr == OFS_HI) rl_q[TMR_W-1:8] <= host_wdata[TMR_W-9:0];
      end
   end

   irb_fifo #(.DEPTH(FIFO_DEPTH), .DW(HOST_DW)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .push   (rx_valid),
      .din    (rx_data),
      .pop    (host_rd && host_addr == OFS_LO && bank == BANK_FIFO),
      .dout   (f_dout),
      .count  (f_cnt),
      .full   (f_full),
      .empty  (f_empty),
      .overrun(f_ovr)
   );

   irb_timer #(.TW(TMR_W), .DIV(TICK_DIV)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q[CB_TEN]),
      .slow  (ctrl_q[CB_SLOW]),
      .reload(rl_q),
      .count (cnt),
      .expire(tmr_expire)
   );

   always_comb begin
      case (ctrl_q[5:4])
         2'b00:   lvl = CW'(1);
         2'b01:   lvl = CW'(4);
         2'b10:   lvl = CW'(8);
         default: lvl = CW'(14);
      endcase
   end

   assign thr_flag = (f_cnt >= lvl);
   assign status   = {4'b0, f_full, f_empty, f_ovr, thr_flag};
   assign rl16     = 16'(rl_q);
   assign cnt16    = 16'(cnt);

   always_comb begin
      host_rdata = '0;
      if (is_ctrl) begin
         host_rdata = ctrl_q;
      end else begin
         case (bank)
            BANK_FIFO: begin
               if (host_addr == OFS_LO)      host_rdata = f_dout;
               else if (host_addr == OFS_HI) host_rdata = status;
            end
            BANK_TIMER: begin
               if (host_addr == OFS_LO)
                  host_rdata = ctrl_q[CB_TEST] ? rl16[7:0] : cnt16[7:0];
               else if (host_addr == OFS_HI)
                  host_rdata = ctrl_q[CB_TEST] ? rl16[15:8] : cnt16[15:8];
            end
            default: host_rdata = '0;
         endcase
      end
   end

   // R4
   thr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_flag |-> !f_empty);
   // R6
   flush_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !(host_wr && is_ctrl)) |=> !ctrl_q[CB_FLUSH]);
   // R10
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_ctrl && ctrl_q[7]) |-> (host_rdata == '0));
endmodule

// File: tb/ir_rx_bank_ctrl_tb.sv
`timescale 1ns/1ps
module ir_rx_bank_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_addr = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       thr_flag, tmr_expire;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   ir_rx_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .thr_flag(thr_flag),
      .tmr_expire(tmr_expire)
   );

   // ---------------- behavioural reference ----------------
   byte unsigned m_q[$];
   bit           m_ovr, m_end, m_exp;
   logic [7:0]   m_ctrl;
   logic [15:0]  m_rl, m_cnt;
   int           m_pre;

   function automatic int level_of(logic [1:0] c);
      case (c)
         2'b00: return 1;
         2'b01: return 4;
         2'b10: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic bit m_thr();
      return m_q.size() >= level_of(m_ctrl[5:4]);
   endfunction

   function automatic logic [7:0] m_read(logic [1:0] a);
      logic [15:0] v;
      if (a == 2'd3) return m_ctrl;
      if (a == 2'd2) return 8'h00;
      case (m_ctrl[7:6])
         2'd0: begin
            if (a == 2'd0) return (m_q.size() > 0) ? m_q[0] : 8'h00;
            return {4'b0, m_q.size() == 16, m_q.size() == 0, m_ovr, m_thr()};
         end
         2'd1: begin
            v = m_ctrl[3] ? m_rl : m_cnt;
            return (a == 2'd0) ? v[7:0] : v[15:8];
         end
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_q.delete(); m_ovr = 0; m_end = 0; m_exp = 0;
         m_ctrl = 0; m_rl = 0; m_cnt = 0; m_pre = 0;
      end else begin
         logic [7:0] nctrl;
         int sz;
         bit tk;
         nctrl = (host_wr && host_addr == 2'd3) ? host_wdata : (m_ctrl & 8'hFD);
         // timer first: uses the reload value before this edge's write
         if (!m_ctrl[2]) begin
            m_end = 0; m_exp = 0; m_pre = 0;
         end else if (!m_end) begin
            m_end = 1; m_cnt = m_rl; m_exp = 0; m_pre = 0;
         end else begin
            tk = m_ctrl[0] ? (m_pre == 7) : 1'b1;
            m_pre = (m_pre + 1) % 8;
            m_exp = 0;
            if (tk) begin
               if (m_cnt == 0) begin m_cnt = m_rl; m_exp = 1; end
               else m_cnt = m_cnt - 1;
            end
         end
         if (m_ctrl[1]) begin
            m_q.delete(); m_ovr = 0;
         end else begin
            sz = m_q.size();
            if (host_rd && host_addr == 2'd0 && m_ctrl[7:6] == 2'd0 && sz > 0)
               void'(m_q.pop_front());
            if (rx_valid) begin
               if (sz >= 16) m_ovr = 1;
               else m_q.push_back(rx_data);
            end
         end
         if (host_wr && host_addr != 2'd3 && m_ctrl[7:6] == 2'd1) begin
            if (host_addr == 2'd0) m_rl[7:0]  = host_wdata;
            if (host_addr == 2'd1) m_rl[15:8] = host_wdata;
         end
         m_ctrl = nctrl;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string tg;
         if (host_addr == 2'd3)          tg = "R2 rdata";
         else if (m_ctrl[7])             tg = "R10 rdata";
         else if (m_ctrl[7:6] == 2'd1)   tg = "R9 rdata";
         else                            tg = "R3 rdata";
         chk(tg, host_rdata, m_read(host_addr));
         chk("R4 thr_flag", thr_flag, m_thr());
         chk("R7 tmr_expire", tmr_expire, m_exp);
      end
   end

   // ---------------- stimulus helpers (start at posedge+1) ----------------
   task automatic step(); @(posedge clk); #1; endtask
   task automatic idle(int n); repeat (n) step(); endtask

   task automatic bus_wr(logic [1:0] a, logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1; step(); host_wr = 0;
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1; @(negedge clk); d = host_rdata; step(); host_rd = 0;
   endtask

   task automatic peek(logic [1:0] a, output logic [7:0] d);
      host_addr = a; @(negedge clk); d = host_rdata; step();
   endtask

   task automatic rx(logic [7:0] b);
      rx_valid = 1; rx_data = b; step(); rx_valid = 0;
   endtask

   task automatic wait_exp(output int c);
      @(negedge clk);
      while (!tmr_expire) @(negedge clk);
      c = cyc;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int c1, c2;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      step();
      // R1 reset state
      peek(2'd3, d); chk("R1 ctrl", d, 8'h00);
      peek(2'd1, d); chk("R1 status", d, 8'h04);
      chk("R1 thr_flag", thr_flag, 0);
      chk("R1 tmr_expire", tmr_expire, 0);
      // R3 order and status
      rx(8'hA1); rx(8'hB2); rx(8'hC3);
      peek(2'd1, d); chk("R3 status", d, 8'h01);
      bus_rd(2'd0, d); chk("R3 pop1", d, 8'hA1);
      bus_rd(2'd0, d); chk("R3 pop2", d, 8'hB2);
      bus_rd(2'd0, d); chk("R3 pop3", d, 8'hC3);
      peek(2'd1, d); chk("R3 status empty", d, 8'h04);
      // R4 thresholds
      bus_wr(2'd3, 8'h10);
      for (int i = 0; i < 3; i++) rx(8'(i));
      chk("R4 3<4", thr_flag, 0);
      rx(8'h03); idle(1); chk("R4 4>=4", thr_flag, 1);
      bus_wr(2'd3, 8'h30); idle(1); chk("R4 4<14", thr_flag, 0);
      for (int i = 0; i < 9; i++) rx(8'(i + 4));
      chk("R4 13<14", thr_flag, 0);
      rx(8'h0D); idle(1); chk("R4 14>=14", thr_flag, 1);
      // R6 self-clearing flush
      bus_wr(2'd3, 8'h32);
      peek(2'd3, d); chk("R6 bit set", d, 8'h32);
      peek(2'd3, d); chk("R6 bit cleared", d, 8'h30);
      peek(2'd1, d); chk("R6 emptied", d, 8'h04);
      // R5 overrun and empty read
      bus_wr(2'd3, 8'h00);
      for (int i = 0; i < 17; i++) rx(8'(8'h40 + i));
      peek(2'd1, d); chk("R5 full+ovr", d, 8'h0B);
      for (int i = 0; i < 16; i++) begin
         bus_rd(2'd0, d); chk("R5 drain", d, 8'h40 + i);
      end
      peek(2'd1, d); chk("R5 ovr sticky", d, 8'h06);
      bus_rd(2'd0, d); chk("R5 empty read", d, 8'h00);
      bus_wr(2'd3, 8'h02); idle(1);
      peek(2'd1, d); chk("R6 ovr cleared", d, 8'h04);
      // R2 and R10 bank switching
      bus_wr(2'd3, 8'h40);
      peek(2'd3, d); chk("R2 bank1 ctrl", d, 8'h40);
      bus_wr(2'd0, 8'h05); bus_wr(2'd1, 8'h00);
      bus_wr(2'd2, 8'hEE);
      peek(2'd2, d); chk("R10 ofs2", d, 8'h00);
      bus_wr(2'd3, 8'hC8);
      peek(2'd3, d); chk("R2 rsv ctrl", d, 8'hC8);
      peek(2'd0, d); chk("R10 rsv read", d, 8'h00);
      bus_wr(2'd0, 8'h77); bus_wr(2'd1, 8'h66);
      rx(8'h99);
      bus_wr(2'd3, 8'h48);
      peek(2'd0, d); chk("R10 write ignored lo", d, 8'h05);
      peek(2'd1, d); chk("R10 write ignored hi", d, 8'h00);
      // R7 timer at one tick per clock
      bus_wr(2'd3, 8'h44);
      wait_exp(c1); wait_exp(c2);
      chk("R7 period div1", c2 - c1, 6);
      step();
      // R8 divide by 8
      bus_wr(2'd3, 8'h45);
      wait_exp(c1); wait_exp(c1); wait_exp(c2);
      chk("R8 period div8", c2 - c1, 48);
      step();
      // R9 test readback versus live count
      bus_wr(2'd3, 8'h4D);
      peek(2'd0, d); chk("R9 test lo", d, 8'h05);
      bus_wr(2'd0, 8'h09);
      peek(2'd0, d); chk("R9 test new lo", d, 8'h09);
      bus_wr(2'd3, 8'h45);
      idle(20);
      bus_wr(2'd3, 8'h40);
      idle(5);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule